// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block is the timing spine of a small processor core. It divides its input clock into four non-overlapping phase slots that repeat in a fixed order. One pass through all four slots is an instruction cycle. Each slot has a fixed job. In slot 1 the program counter advances and the instruction register takes the word fetched last cycle. Slot 2 carries the operand-read strobe. Slot 4 carries the destination-write strobe, and the word on the program-memory bus is captured there.

Fetch and execute overlap. While the word at the current address is fetched, the word fetched one cycle earlier executes, so straight-line code retires one instruction per instruction cycle. The execute logic may raise a branch request with a target address. The sequencer then loads that target as the next fetch address. It also replaces the word already prefetched with a NOP, so a control transfer costs two instruction cycles. A divide-by-four clock output, aligned to the instruction cycle, is also provided.

Top module: `qseq_core`

## Requirements
- R1: Exactly one of the four bits of `q_strobe` is high on every input clock. The bits step 0,1,2,3,0,… one per clock, and `phase_idx` holds the index of the high bit (0 = slot 1 … 3 = slot 4).
- R2: While `rst_n` is low and after reset: `phase_idx` is 0, `prog_addr` is 0, `ir_out` holds the NOP word (all zeros), and `bubble` is 1. The first instruction cycle therefore executes nothing while address 0 is fetched.
- R3: `prog_addr` changes only at the clock edge that ends slot 1. Without a branch it rises by exactly one per instruction cycle and wraps from 8191 to 0.
- R4: The value of `instr_in` at the edge that ends slot 4 appears on `ir_out` after the edge that ends the following slot 1, provided no flush is pending. `ir_out` changes at no other edge.
- R5: In an instruction cycle whose `bubble` is 0, `rd_strobe` is high exactly in slot 2 and `wr_strobe` is high exactly in slot 4.
- R6: If `branch_req` is high at the edge ending slot 4 of a cycle with `bubble` 0, then `prog_addr` equals the `branch_target` sampled at that edge, from the edge that ends the next slot 1 onward.
- R7: The cycle after an accepted branch is a forced NOP. `ir_out` is the NOP word and `bubble` is 1, and neither `rd_strobe` nor `wr_strobe` is raised in that cycle.
- R8: `branch_req` has no effect when it is high only in slots 1–3, or when it is high in a cycle whose `bubble` is 1. In those cases `prog_addr` keeps its sequential progression.
- R9: `clk_div4` is high during slots 1 and 2 and low during slots 3 and 4. It rises together with slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 13 | Program-memory fetch address |
| instr_in | input | 14 | Word returned by program memory |
| ir_out | output | 14 | Instruction register being executed |
| bubble | output | 1 | Current instruction is a forced or reset NOP |
| branch_req | input | 1 | Execute logic requests a control transfer |
| branch_target | input | 13 | Address to transfer to |
| q_strobe | output | 4 | One-hot phase strobes, bit 0 = slot 1 |
| phase_idx | output | 2 | Index of the active phase slot |
| rd_strobe | output | 1 | Operand-read strobe (slot 2) |
| wr_strobe | output | 1 | Destination-write strobe (slot 4) |
| clk_div4 | output | 1 | Input clock divided by four |

## Verification
The bench builds the block with its default parameters. These are a 13-bit address, a 14-bit instruction word, an all-zero NOP, gated strobes and a registered divided clock. With this build the 8191-to-0 wrap can be reached in a few dozen cycles by first branching to 8190. Held and randomly timed branch requests land in every phase slot and in bubble cycles, so both accepted transfers and ignored requests occur back to back. A reset in the middle of the run checks that the reset state can be re-entered from arbitrary pipeline contents.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
   typedef enum logic [1:0] {
      PH_S1 = 2'd0,
      PH_S2 = 2'd1,
      PH_S3 = 2'd2,
      PH_S4 = 2'd3
   } phase_e;

   localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
   import qseq_pkg::*;
#(
   parameter bit CLKOUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output phase_e                phase,
   output logic [NUM_PHASES-1:0] strobes,
   output logic                  clk_div4
);
   phase_e phase_q;
   phase_e phase_nx;

   assign phase_nx = phase_e'(phase_q + 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_S1;
      else        phase_q <= phase_nx;
   end

   assign phase = phase_q;

   for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
      assign strobes[i] = (phase_q == phase_e'(i));
   end

   if (CLKOUT_REG) begin : g_clk_reg
      logic div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) div_q <= 1'b1;
         else        div_q <= (phase_nx == PH_S1) || (phase_nx == PH_S2);
      end
      assign clk_div4 = div_q;
   end else begin : g_clk_comb
      assign clk_div4 = (phase_q == PH_S1) || (phase_q == PH_S2);
   end

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (phase == phase_e'($past(phase) + 2'd1)));

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(strobes));

   p_div_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(clk_div4)) |-> strobes[0]);
endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit
   import qseq_pkg::*;
#(
   parameter int unsigned PC_W      = 13,
   parameter logic [PC_W-1:0] RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  phase_e          phase,
   input  logic            take_branch,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_VEC;
         next_q <= RESET_VEC;
      end else begin
         if (phase == PH_S4) next_q <= take_branch ? target : (pc_q + STEP);
         if (phase == PH_S1) pc_q   <= next_q;
      end
   end

   assign pc = pc_q;

   p_pc_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (pc != $past(pc))) |-> ($past(phase) == PH_S1));
endmodule

// File: rtl/qseq_ir_unit.sv
module qseq_ir_unit
   import qseq_pkg::*;
#(
   parameter int unsigned IW       = 14,
   parameter logic [IW-1:0] NOP_WORD = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  phase_e        phase,
   input  logic [IW-1:0] fetch_word,
   input  logic          flush_set,
   output logic [IW-1:0] ir,
   output logic          bubble
);
   logic [IW-1:0] hold_q;
   logic          flush_q;
   logic [IW-1:0] ir_q;
   logic          bub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= NOP_WORD;
         flush_q <= 1'b1;
         ir_q    <= NOP_WORD;
         bub_q   <= 1'b1;
      end else begin
         if (phase == PH_S4) begin
            hold_q  <= fetch_word;
            flush_q <= flush_set;
         end
         if (phase == PH_S1) begin
            ir_q  <= flush_q ? NOP_WORD : hold_q;
            bub_q <= flush_q;
         end
      end
   end

   assign ir     = ir_q;
   assign bubble = bub_q;

   p_ir_slot1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (ir != $past(ir))) |-> ($past(phase) == PH_S1));

   p_bubble_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |-> (ir == NOP_WORD));
endmodule

// File: rtl/qseq_core.sv
module qseq_core
   import qseq_pkg::*;
#(
   parameter int unsigned PC_W       = 13,
   parameter int unsigned IW         = 14,
   parameter logic [IW-1:0] NOP_WORD = '0,
   parameter bit          GATE_STROBES = 1'b1,
   parameter bit          CLKOUT_REG   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] prog_addr,
   input  logic [IW-1:0]   instr_in,
   output logic [IW-1:0]   ir_out,
   output logic            bubble,
   input  logic            branch_req,
   input  logic [PC_W-1:0] branch_target,
   output logic [3:0]      q_strobe,
   output logic [1:0]      phase_idx,
   output logic            rd_strobe,
   output logic            wr_strobe,
   output logic            clk_div4
);
   if (PC_W < 2 || PC_W > 32) begin : g_bad_pc_w
      $error("qseq_core: PC_W out of range");
   end
   if (IW < 1) begin : g_bad_iw
      $error("qseq_core: IW must be positive");
   end

   phase_e phase;
   logic   take_branch;

   qseq_phase_gen #(.CLKOUT_REG(CLKOUT_REG)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .strobes  (q_strobe),
      .clk_div4 (clk_div4)
   );

   assign take_branch = (phase == PH_S4) && branch_req && !bubble;

   qseq_pc_unit #(.PC_W(PC_W), .RESET_VEC('0)) u_pc (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .take_branch (take_branch),
      .target      (branch_target),
      .pc          (prog_addr)
   );

   qseq_ir_unit #(.IW(IW), .NOP_WORD(NOP_WORD)) u_ir (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .fetch_word (instr_in),
      .flush_set  (take_branch),
      .ir         (ir_out),
      .bubble     (bubble)
   );

   assign phase_idx = phase;

   if (GATE_STROBES) begin : g_gated
      assign rd_strobe = q_strobe[1] && !bubble;
      assign wr_strobe = q_strobe[3] && !bubble;

      p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         bubble |-> (!rd_strobe && !wr_strobe));
   end else begin : g_raw
      assign rd_strobe = q_strobe[1];
      assign wr_strobe = q_strobe[3];
   end

   p_rd_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |-> (phase_idx == 2'd1));

   p_wr_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> (phase_idx == 2'd3));

   p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_branch |-> ##2 (bubble && (ir_out == NOP_WORD)));

   p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_branch |-> ##2 (prog_addr == $past(branch_target, 2)));
endmodule

// File: tb/tb_qseq_core.sv
module tb_qseq_core;
   localparam int PC_W = 13;
   localparam int IW   = 14;
   localparam int LAST = 3700;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] prog_addr;
   logic [IW-1:0]   instr_in;
   logic [IW-1:0]   ir_out;
   logic            bubble;
   logic            branch_req = 1'b0;
   logic [PC_W-1:0] branch_target = '0;
   logic [3:0]      q_strobe;
   logic [1:0]      phase_idx;
   logic            rd_strobe, wr_strobe, clk_div4;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   qseq_core dut (
      .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .instr_in(instr_in),
      .ir_out(ir_out), .bubble(bubble), .branch_req(branch_req),
      .branch_target(branch_target), .q_strobe(q_strobe), .phase_idx(phase_idx),
      .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .clk_div4(clk_div4)
   );

   function automatic logic [IW-1:0] mem_word(input logic [PC_W-1:0] a);
      logic [31:0] h;
      h = {19'd0, a} * 32'h0000_9E37 ^ 32'h0000_15A5;
      return h[IW-1:0] | 14'h0001;
   endfunction

   assign instr_in = mem_word(prog_addr);

   // reference model built from the requirements
   logic [1:0]      m_ph;
   logic [PC_W-1:0] m_pc, m_nx;
   logic [IW-1:0]   m_hold, m_ir;
   logic            m_flush, m_bub;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 2'd0; m_pc <= '0; m_nx <= '0;
         m_hold <= '0; m_ir <= '0; m_flush <= 1'b1; m_bub <= 1'b1;
      end else begin
         m_ph <= m_ph + 2'd1;
         if (m_ph == 2'd3) begin
            m_hold  <= instr_in;
            m_flush <= branch_req && !m_bub;
            m_nx    <= (branch_req && !m_bub) ? branch_target : m_pc + 13'd1;
         end
         if (m_ph == 2'd0) begin
            m_pc  <= m_nx;
            m_ir  <= m_flush ? '0 : m_hold;
            m_bub <= m_flush;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      if (!rst_n) begin
         chk("R2", "phase", phase_idx, 0);
         chk("R2", "prog_addr", prog_addr, 0);
         chk("R2", "ir_out", ir_out, 0);
         chk("R2", "bubble", bubble, 1);
      end else begin
         chk("R1", "phase_idx", phase_idx, m_ph);
         chk("R1", "q_strobe", q_strobe, 4'b0001 << m_ph);
         chk("R9", "clk_div4", clk_div4, (m_ph < 2'd2) ? 1 : 0);
         chk("R3_R6_R8", "prog_addr", prog_addr, m_pc);
         chk("R4_R7", "ir_out", ir_out, m_ir);
         chk("R7", "bubble", bubble, m_bub);
         chk("R5_R7", "rd_strobe", rd_strobe, (m_ph == 2'd1 && !m_bub) ? 1 : 0);
         chk("R5_R7", "wr_strobe", wr_strobe, (m_ph == 2'd3 && !m_bub) ? 1 : 0);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < LAST; n++) begin
         @(negedge clk);
         check_all();
         if (n == 2) rst_n = 1'b1;
         if (n == 2000) rst_n = 1'b0;  // mid-run reset, R2
         if (n == 2003) rst_n = 1'b1;
         if (n >= 40 && n < 44) begin          // jump near the top, R6
            branch_req = 1'b1; branch_target = 13'd8190;
         end else if (n < 140) begin           // straight run through wrap, R3
            branch_req = 1'b0;
         end else if (n >= 3500 && n < 3580) begin  // held request, R7 R8
            branch_req = 1'b1; branch_target = PC_W'($urandom);
         end else begin
            branch_req = ($urandom % 5) == 0;
            branch_target = PC_W'($urandom);
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule